// File: doc/BRIEF.md
# CD sector sync generator selector

This block produces the one-clock sector-start strobe for a CD-ROM data decoder. Its input is a stream of 16-bit words, each qualified by a word-valid strobe. A sector is 2352 bytes, which is 1176 words, and the block offers two ways to find where each sector starts.

The first way is a flywheel counter. It counts valid words and marks the last word of every 1176-word period. The second way is a pattern detector. It recognises the 12-byte sector sync mark in the incoming words. Each source has its own enable input, and a source can drive the strobe only while its enable is high. A detected mark that is enabled also realigns the flywheel, so that the generated sync keeps running in step with the data when the mark is later lost.

The current word index within the sector is also output, so that a downstream block can locate the header and data fields.

Top module: `cd_sync_sel`

## Requirements
- R1: A synchronous active-high reset clears the strobe to 0, the word index to 0 and the pattern history. A sync mark that is split by a reset is therefore not detected.
- R2: `word_idx_o` counts valid words from 0 to 1175 and then wraps to 0. It changes only in the clock after a cycle with `word_vld` high.
- R3: When `gen_en` is 1, a valid word accepted while `word_idx_o` is 1175 raises `sync_o`. After reset, the first such sync comes with the 1176th valid word.
- R4: When `gen_en` is 0, the flywheel never raises `sync_o`. The counter keeps running.
- R5: The detector matches six consecutive valid words: 16'h00FF, four words of 16'hFFFF, then 16'hFF00. The earlier byte of each pair is in bits 15:8. The match is flagged on the sixth word.
- R6: When `det_en` is 0, a detected mark neither raises `sync_o` nor changes the counter.
- R7: When `det_en` is 1, a detected mark sets `word_idx_o` to 0. The next generated sync then comes 1176 valid words later.
- R8: When a generated sync and an enabled detected sync fall on the same word, they give a single strobe, and the index goes to 0.
- R9: `sync_o` is registered. It is high for exactly one clock, in the cycle after the valid word that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Qualifies `word_in` in this cycle |
| word_in | input | 16 | Data word, earlier byte in bits 15:8 |
| gen_en | input | 1 | Lets the flywheel sync reach the output |
| det_en | input | 1 | Lets the detected sync reach the output and realign the counter |
| sync_o | output | 1 | One-clock sector-start strobe |
| word_idx_o | output | 11 | Word index within the sector, 0 to 1175 |

## Verification
The flywheel wrap and a detected sync mark can occur on the same word. The bench provokes this by placing a full mark so that its last word is the 1176th word after reset, with both enables high. The check expects exactly one strobe and an index of 0 afterwards.

Random streams also place marks at arbitrary phases, with random gaps in the valid strobe and random settings of the enables. A bench model predicts each strobe and each index value, and every cycle is compared against it.

// File: rtl/cd_sync_pkg.sv
package cd_sync_pkg;
  localparam int WORD_W       = 16;
  localparam int SECTOR_WORDS = 1176;
  localparam int MARK_WORDS   = 6;
  localparam int IDX_W        = $clog2(SECTOR_WORDS);

  // Byte b of the 12-byte sector mark: 00h at both ends, FFh between them.
  function automatic logic [7:0] mark_byte(input int b);
    return (b == 0 || b == 2 * MARK_WORDS - 1) ? 8'h00 : 8'hFF;
  endfunction

  // Word i of the mark. The earlier byte goes in the upper half.
  function automatic logic [WORD_W-1:0] mark_word(input int i);
    return {mark_byte(2 * i), mark_byte(2 * i + 1)};
  endfunction
endpackage

// File: rtl/cd_mark_det.sv
module cd_mark_det
  import cd_sync_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = MARK_WORDS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] word,
  output logic         hit
);
  localparam int HIST = N - 1;

  // hist[0] holds the most recent valid word before the current one.
  logic [W-1:0] hist [HIST];
  logic [HIST-1:0] hist_ok;

  genvar k;
  generate
    for (k = 0; k < HIST; k++) begin : g_cmp
      assign hist_ok[k] = (hist[k] == W'(mark_word(N - 2 - k)));
    end
  endgenerate

  assign hit = vld && (word == W'(mark_word(N - 1))) && (&hist_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (vld) begin
      hist[0] <= word;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/cd_flywheel.sv
module cd_flywheel
  import cd_sync_pkg::*;
#(
  parameter int PERIOD = SECTOR_WORDS,
  parameter int CW     = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          realign,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap = vld && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (vld && realign) cnt <= '0;
    else if (wrap)           cnt <= '0;
    else if (vld)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cd_sync_sel.sv
module cd_sync_sel
  import cd_sync_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int PERIOD = SECTOR_WORDS,
  parameter int N      = MARK_WORDS,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_vld,
  input  logic [W-1:0]  word_in,
  input  logic          gen_en,
  input  logic          det_en,
  output logic          sync_o,
  output logic [CW-1:0] word_idx_o
);
  logic mark_hit;
  logic fly_wrap;
  logic take_det;

  cd_mark_det #(.W(W), .N(N)) u_det (
    .clk  (clk),
    .rst  (rst),
    .vld  (word_vld),
    .word (word_in),
    .hit  (mark_hit)
  );

  assign take_det = det_en && mark_hit;

  cd_flywheel #(.PERIOD(PERIOD), .CW(CW)) u_fly (
    .clk     (clk),
    .rst     (rst),
    .vld     (word_vld),
    .realign (take_det),
    .cnt     (word_idx_o),
    .wrap    (fly_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_o <= 1'b0;
    else     sync_o <= (gen_en && fly_wrap) || take_det;
  end
endmodule

// File: rtl/cd_sync_chk.sv
module cd_sync_chk #(
  parameter int PERIOD = 1176,
  parameter int CW     = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          word_vld,
  input logic          gen_en,
  input logic          det_en,
  input logic          sync_o,
  input logic [CW-1:0] word_idx_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  // R9
  sync_after_word_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_o && !$past(rst)) |-> $past(word_vld));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(word_vld)) |-> $stable(word_idx_o));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    word_idx_o <= LAST);

  // R4
  gen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_o && !$past(rst) && !$past(det_en)) |->
      ($past(gen_en) && $past(word_idx_o) == LAST));

  // R6
  det_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_o && !$past(rst) && !$past(gen_en)) |-> $past(det_en));

  // R7
  realign_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_o && !$past(rst) && $past(word_idx_o) != LAST) |-> (word_idx_o == '0));
endmodule

bind cd_sync_sel cd_sync_chk #(.PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_vld   (word_vld),
  .gen_en     (gen_en),
  .det_en     (det_en),
  .sync_o     (sync_o),
  .word_idx_o (word_idx_o)
);

// File: tb/sim_cd_sync_sel.sv
module sim_cd_sync_sel;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 1176;
  localparam int LAST       = PERIOD - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic        gen_en = 1'b0;
  logic        det_en = 1'b0;
  logic        sync_o;
  logic [10:0] word_idx_o;

  int total = 0;
  int bad   = 0;
  int m_cnt = 0;
  logic [15:0] m_hist [5];
  int nsync = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cd_sync_sel u0 (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .gen_en(gen_en), .det_en(det_en), .sync_o(sync_o), .word_idx_o(word_idx_o)
  );

  // R5 encoding: 00FF, FFFF x4, FF00
  function automatic logic [15:0] pat(input int i);
    if (i == 0) return 16'h00FF;
    if (i == 5) return 16'hFF00;
    return 16'hFFFF;
  endfunction

  function automatic bit m_match(input logic [15:0] w);
    bit ok = (w == pat(5));
    for (int k = 0; k < 5; k++) if (m_hist[k] != pat(4 - k)) ok = 0;
    return ok;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = 0;
    for (int k = 0; k < 5; k++) m_hist[k] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; word_vld = 1'b0;
    m_reset();
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(sync_o === 1'b0, "R1 sync after reset", int'(sync_o), 0);
    check(word_idx_o === 11'd0, "R1 index after reset", int'(word_idx_o), 0);
  endtask

  task automatic step(input logic v, input logic [15:0] w, input string tag);
    bit exp, hit;
    @(negedge clk);
    word_vld = v; word_in = w;
    hit = v && m_match(w);
    exp = v && ((gen_en && m_cnt == LAST) || (det_en && hit));
    if (v) begin
      for (int k = 4; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = w;
      if (det_en && hit)      m_cnt = 0;
      else if (m_cnt == LAST) m_cnt = 0;
      else                    m_cnt = m_cnt + 1;
    end
    @(posedge clk); #1;
    if (sync_o) nsync++;
    check(sync_o === exp, tag, int'(sync_o), int'(exp));
    check(int'(word_idx_o) == m_cnt, tag, int'(word_idx_o), m_cnt);
  endtask

  function automatic logic [15:0] rnd_word();
    logic [15:0] w = 16'($urandom);
    if (w == 16'hFF00) w = 16'h1234;
    return w;
  endfunction

  task automatic send_mark(input string tag);
    for (int i = 0; i < 6; i++) step(1'b1, pat(i), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R3: flywheel only, one sync at the 1176th valid word
    gen_en = 1; det_en = 0; nsync = 0;
    for (int i = 0; i < PERIOD; i++) step(1'b1, rnd_word(), "R3 flywheel");
    check(nsync == 1, "R3 one sync per period", nsync, 1);
    check(word_idx_o == 0, "R3 wrap index", int'(word_idx_o), 0);

    // R2: idle cycles hold the index
    step(1'b1, rnd_word(), "R2 advance");
    for (int i = 0; i < 5; i++) step(1'b0, rnd_word(), "R2 hold");
    check(word_idx_o == 1, "R2 index held", int'(word_idx_o), 1);

    // R6: disabled detection neither strobes nor realigns
    gen_en = 0; det_en = 0; nsync = 0;
    send_mark("R6 det disabled");
    check(nsync == 0, "R6 no strobe", nsync, 0);
    check(word_idx_o == 7, "R6 no realign", int'(word_idx_o), 7);

    // R4: flywheel disabled over a full period
    nsync = 0;
    for (int i = 0; i < PERIOD; i++) step(1'b1, rnd_word(), "R4 gen disabled");
    check(nsync == 0, "R4 no strobe", nsync, 0);

    // R5/R7: enabled detection strobes and realigns, gaps within the mark
    gen_en = 1; det_en = 1; nsync = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 16'h00FF, "R5 gap");
      step(1'b1, pat(i), "R5 mark");
    end
    check(nsync == 1, "R5 detected", nsync, 1);
    check(word_idx_o == 0, "R7 realigned", int'(word_idx_o), 0);
    nsync = 0;
    for (int i = 0; i < LAST; i++) step(1'b1, rnd_word(), "R7 spacing");
    check(nsync == 0, "R7 no early sync", nsync, 0);
    step(1'b1, rnd_word(), "R7 sync at 1176");
    check(nsync == 1, "R7 sync after 1176 words", nsync, 1);

    // R1: a mark split by reset is not detected
    for (int i = 0; i < 5; i++) step(1'b1, pat(i), "R1 partial");
    do_reset();
    nsync = 0;
    step(1'b1, pat(5), "R1 split mark");
    check(nsync == 0, "R1 history cleared", nsync, 0);

    // R8: coincidence of flywheel wrap and detection
    do_reset();
    nsync = 0;
    for (int i = 0; i < PERIOD - 6; i++) step(1'b1, rnd_word(), "R8 lead");
    send_mark("R8 coincide");
    check(nsync == 1, "R8 single strobe", nsync, 1);
    check(word_idx_o == 0, "R8 index zero", int'(word_idx_o), 0);

    // R9: the strobe lasts one clock
    step(1'b0, 16'h0, "R9 single clock");
    check(sync_o === 1'b0, "R9 strobe dropped", int'(sync_o), 0);

    // random mix of phases, gaps and enables
    for (int blk = 0; blk < 16; blk++) begin
      gen_en = $urandom_range(0, 3) != 0;
      det_en = $urandom_range(0, 3) != 0;
      for (int i = 0; i < 2000; i++) begin
        if ($urandom_range(0, 299) == 0) begin
          for (int j = 0; j < 6; j++) begin
            if ($urandom_range(0, 3) == 0) step(1'b0, rnd_word(), "R5 random gap");
            step(1'b1, pat(j), "R7 random mark");
          end
        end else begin
          step($urandom_range(0, 3) != 0, rnd_word(), "R3 random");
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule